// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is a synchronous serial master clocked by the system clock. A single write of a transmit word starts a full-duplex transfer. The word is shifted out on the serial data output while a word of the same length is captured from the serial data input. The serial clock runs in any of the four polarity and phase modes. Its half period is programmable, and the word can be sent most-significant bit first or least-significant bit first.

The host sets the mode, bit order, half-period count and word length, then pulses the write strobe together with the data. The block lowers its active-low select and sets up the first bit with a lead time that depends on the phase mode. It then toggles the serial clock. When the transfer ends, it raises the select, loads the received word right-aligned and pulses a one-cycle done strobe. After the transfer, the output line keeps the last bit sent until the next accepted write.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, csN is 1, busy is 0, done is 0, sclk is 0, mosi is 0 and rxData is 0.
- R2: The half period H equals halfPeriod clamped to the range 4..128 system clocks. Successive SCLK edges within a transfer are exactly H clocks apart, which gives serial clock periods of 8 to 256 clocks.
- R3: While idle, sclk equals cpol (the idle level). A transfer has an even number of edges, so sclk ends at the idle level.
- R4: On an accepted write, csN goes low and the first bit appears on mosi in the same cycle. The first SCLK edge follows H clocks later when cpha is 0, and 2H clocks later when cpha is 1.
- R5: Edges with index e = 0..2N-1 are receive edges when e mod 2 equals cpha; the others are transmit edges. mosi changes only on a transmit edge and stays stable across every receive edge. The transmit edge at e = 0 (phase 1) and the one at e = 2N-1 (phase 0) leave mosi unchanged.
- R6: miso is sampled on each receive edge. Bit j of the transfer lands at position j of rxData when lsbFirst is 1, and at position N-1-j when lsbFirst is 0. Upper bits of rxData are zero.
- R7: With lsbFirst = 1 the bits go out as txData[0] up to txData[N-1]. With lsbFirst = 0 they go out as txData[N-1] down to txData[0]. txData bits at N and above are not sent.
- R8: The word length N equals wordLen clamped to the range 2..16.
- R9: busy stays high from the accepted write until H clocks after the last edge, which is lead + 2N·H cycles. In the cycle busy falls, done is 1 and rxData holds the new word. done lasts exactly one cycle.
- R10: A txWrite while busy is ignored. The transfer in progress, its bits and its received word are unchanged, and no new transfer follows.
- R11: After a transfer, mosi keeps the last bit sent until the next accepted write.
- R12: csN is low exactly while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: first edge samples; 1: first edge launches |
| lsbFirst | input | 1 | 1: least-significant bit first |
| halfPeriod | input | 8 | Half period in system clocks (clamped 4..128) |
| wordLen | input | 5 | Bits per word (clamped 2..16) |
| txWrite | input | 1 | Write strobe; starts a transfer when idle |
| txData | input | 16 | Word to transmit |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rxData | output | 16 | Last received word, right-aligned |

## Verification
The assertions check five things on every cycle: select tracks busy, done is a single cycle that coincides with the fall of busy, mosi holds while idle and between SCLK edges, and sclk sits at the idle level outside a transfer. Other properties depend on mode, word length and data, so only the bench scenarios can show them. These are the exact lead time and edge spacing after clamping, the bit sequence in each order, the right-aligned received word and the rejection of a mid-transfer write.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  // strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic load;    // accept a new word, present first bit
    logic shift;   // transmit edge: present next bit
    logic sample;  // receive edge: capture serial input
    logic finish;  // transfer over: publish received word
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } spiState_e;

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128,
  parameter int LEN_W    = 5,
  parameter int MIN_BITS = 2,
  parameter int MAX_BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             txWrite,
  output spiStrobe_t       strobe,
  output logic [LEN_W-1:0] lenClamp,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W  = HALF_W + 1;
  localparam int EDGE_W = $clog2(2 * MAX_BITS) + 1;

  spiState_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     halfQ;
  logic [CNT_W-1:0]     halfClamp;
  logic [CNT_W-1:0]     leadCnt;
  logic [EDGE_W-1:0]    edgeIdx;
  logic [EDGE_W-1:0]    lastEdge;
  logic                 cphaQ;
  logic                 edgeNow;
  logic                 rxEdge;

  // clamp the programmed half period and word length
  always_comb begin
    if ({1'b0, halfPeriod} < CNT_W'(MIN_HALF))      halfClamp = CNT_W'(MIN_HALF);
    else if ({1'b0, halfPeriod} > CNT_W'(MAX_HALF)) halfClamp = CNT_W'(MAX_HALF);
    else                                            halfClamp = {1'b0, halfPeriod};

    if (wordLen < LEN_W'(MIN_BITS))      lenClamp = LEN_W'(MIN_BITS);
    else if (wordLen > LEN_W'(MAX_BITS)) lenClamp = LEN_W'(MAX_BITS);
    else                                 lenClamp = wordLen;

    leadCnt = cpha ? (halfClamp << 1) : halfClamp;
  end

  assign edgeNow = (state == ST_XFER) && (cnt == '0);
  assign rxEdge  = (edgeIdx[0] == cphaQ);

  always_comb begin
    strobe.load   = (state == ST_IDLE) && txWrite;
    strobe.sample = edgeNow && rxEdge;
    strobe.shift  = edgeNow && !rxEdge
                    && !(cphaQ && (edgeIdx == '0))
                    && !(!cphaQ && (edgeIdx == lastEdge));
    strobe.finish = (state == ST_TAIL) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      halfQ    <= CNT_W'(MIN_HALF);
      edgeIdx  <= '0;
      lastEdge <= '0;
      cphaQ    <= 1'b0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (txWrite) begin
            halfQ    <= halfClamp;
            cphaQ    <= cpha;
            lastEdge <= EDGE_W'({lenClamp, 1'b0}) - EDGE_W'(1);
            edgeIdx  <= '0;
            cnt      <= leadCnt - CNT_W'(1);
            csN      <= 1'b0;
            busy     <= 1'b1;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (cnt == '0) begin
            sclk    <= ~sclk;
            cnt     <= halfQ - CNT_W'(1);
            edgeIdx <= edgeIdx + EDGE_W'(1);
            if (edgeIdx == lastEdge) state <= ST_TAIL;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            csN   <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  spiStrobe_t          strobe,
  input  logic                lsbFirst,
  input  logic [LEN_W-1:0]    lenClamp,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rxData
);

  logic [MAX_BITS-1:0] txShift;
  logic [MAX_BITS-1:0] rxShift;
  logic [MAX_BITS-1:0] msbAligned;
  logic [LEN_W-1:0]    lenQ;
  logic                lsbQ;

  // left-justify the word so the first bit of a short word sits at the top
  assign msbAligned = txData << (LEN_W'(MAX_BITS) - lenClamp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      lenQ    <= LEN_W'(MAX_BITS);
      lsbQ    <= 1'b0;
      mosi    <= 1'b0;
      rxData  <= '0;
    end else begin
      if (strobe.load) begin
        lsbQ    <= lsbFirst;
        lenQ    <= lenClamp;
        rxShift <= '0;
        if (lsbFirst) begin
          txShift <= txData;
          mosi    <= txData[0];
        end else begin
          txShift <= msbAligned;
          mosi    <= msbAligned[MAX_BITS-1];
        end
      end
      if (strobe.shift) begin
        if (lsbQ) begin
          txShift <= txShift >> 1;
          mosi    <= txShift[1];
        end else begin
          txShift <= txShift << 1;
          mosi    <= txShift[MAX_BITS-2];
        end
      end
      if (strobe.sample) begin
        if (lsbQ) rxShift <= {miso, rxShift[MAX_BITS-1:1]};
        else      rxShift <= {rxShift[MAX_BITS-2:0], miso};
      end
      if (strobe.finish) begin
        rxData <= lsbQ ? (rxShift >> (LEN_W'(MAX_BITS) - lenQ)) : rxShift;
      end
    end
  end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128,
  parameter int MIN_BITS = 2,
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpol,
  input  logic                cpha,
  input  logic                lsbFirst,
  input  logic [HALF_W-1:0]   halfPeriod,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                txWrite,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                csN,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rxData
);

  spiStrobe_t       strobe;
  logic [LEN_W-1:0] lenClamp;

  spi_shift_ctrl #(
    .HALF_W(HALF_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF),
    .LEN_W(LEN_W), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha),
    .halfPeriod(halfPeriod), .wordLen(wordLen), .txWrite(txWrite),
    .strobe(strobe), .lenClamp(lenClamp), .sclk(sclk), .csN(csN),
    .busy(busy), .done(done)
  );

  spi_shift_dp #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(lsbFirst),
    .lenClamp(lenClamp), .txData(txData), .miso(miso),
    .mosi(mosi), .rxData(rxData)
  );

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic txWrite,
  input logic sclk,
  input logic mosi,
  input logic csN,
  input logic busy,
  input logic done
);

  // R12
  cs_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN == !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R11
  mosi_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !txWrite) |=> $stable(mosi));

  // R5
  mosi_edge_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(sclk)) |-> $stable(mosi));

  // R3
  sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (sclk == $past(cpol)));

endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .txWrite(txWrite), .sclk(sclk),
  .mosi(mosi), .csN(csN), .busy(busy), .done(done)
);

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, lsbFirst = 1'b0;
  logic [7:0]  halfPeriod = 8'd4;
  logic [4:0]  wordLen = 5'd8;
  logic        txWrite = 1'b0;
  logic [15:0] txData = '0;
  logic        miso = 1'b0;
  logic        sclk, mosi, csN, busy, done;
  logic [15:0] rxData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_shift_master u_dut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst),
    .halfPeriod(halfPeriod), .wordLen(wordLen), .txWrite(txWrite),
    .txData(txData), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN),
    .busy(busy), .done(done), .rxData(rxData)
  );

  typedef struct packed {
    logic        pol;
    logic        pha;
    logic        lsb;
    logic [4:0]  len;
    logic [7:0]  half;
    logic [15:0] tx;
    logic [15:0] mi;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 5'd8,  8'd4,   16'h00A5, 16'h003C},
    '{1'b0, 1'b1, 1'b0, 5'd8,  8'd5,   16'h0096, 16'h00C3},
    '{1'b1, 1'b0, 1'b1, 5'd12, 8'd6,   16'hFABC, 16'hF5A5},
    '{1'b1, 1'b1, 1'b1, 5'd16, 8'd4,   16'hBEEF, 16'h1234},
    '{1'b0, 1'b0, 1'b1, 5'd2,  8'd7,   16'h0002, 16'h0001},
    '{1'b1, 1'b0, 1'b0, 5'd1,  8'd1,   16'h0001, 16'h0002},
    '{1'b0, 1'b1, 1'b0, 5'd20, 8'd200, 16'h8001, 16'hF00F},
    '{1'b1, 1'b1, 1'b0, 5'd5,  8'd9,   16'h0013, 16'h000A}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic bitOf(logic [15:0] w, int j, int n, logic lsb);
    return lsb ? w[j] : w[n-1-j];
  endfunction

  task automatic runXfer(input vec_t v, input bit glitch);
    int h, n, lead, c, e, edgeErr, bitErr;
    logic prev;
    h = (v.half < 4) ? 4 : ((v.half > 128) ? 128 : int'(v.half));
    n = (v.len < 2) ? 2 : ((v.len > 16) ? 16 : int'(v.len));
    lead = v.pha ? 2 * h : h;
    @(negedge clk);
    cpol = v.pol; cpha = v.pha; lsbFirst = v.lsb;
    halfPeriod = v.half; wordLen = v.len;
    miso = bitOf(v.mi, 0, n, v.lsb);
    @(negedge clk);
    txWrite = 1'b1; txData = v.tx;
    @(negedge clk);
    txWrite = 1'b0;
    c = 0; e = 0; edgeErr = 0; bitErr = 0; prev = v.pol;
    // R4 R12: select and first bit at write
    chk(csN == 1'b0 && busy == 1'b1, "R12", "select at start", int'(csN), 0);
    chk(mosi == bitOf(v.tx, 0, n, v.lsb), "R4", "first bit", int'(mosi),
        int'(bitOf(v.tx, 0, n, v.lsb)));
    chk(sclk == v.pol, "R3", "idle level at start", int'(sclk), int'(v.pol));
    while (c < 8000) begin
      @(negedge clk);
      c++;
      if (glitch && c == 3) begin txWrite = 1'b1; txData = ~v.tx; end
      if (glitch && c == 4) txWrite = 1'b0;
      if (sclk != prev) begin
        if (e == 0)
          chk(c == lead, "R4", "first edge delay", c, lead);
        else if (c != lead + e * h)
          edgeErr++;
        if ((e % 2) == int'(v.pha)) begin
          if (mosi != bitOf(v.tx, e / 2, n, v.lsb)) bitErr++;
        end else begin
          if (v.pha) miso = bitOf(v.mi, e / 2, n, v.lsb);
          else if ((e + 1) / 2 < n) miso = bitOf(v.mi, (e + 1) / 2, n, v.lsb);
        end
        e++;
      end
      prev = sclk;
      if (!busy) break;
    end
    // R2: edge spacing after clamp
    chk(edgeErr == 0 && e == 2 * n, "R2", "edge spacing/count", e, 2 * n);
    // R5 R7 R10: bit sequence at receive edges
    chk(bitErr == 0, glitch ? "R10" : "R7", "mosi bit errors", bitErr, 0);
    chk(c == lead + 2 * n * h, "R9", "busy length", c, lead + 2 * n * h);
    chk(done == 1'b1 && csN == 1'b1, "R9", "done/select at end", int'(done), 1);
    chk(rxData == (v.mi & 16'((32'd1 << n) - 1)),
        (int'(v.len) != n) ? "R8" : "R6", "received word",
        int'(rxData), int'(v.mi & 16'((32'd1 << n) - 1)));
    chk(sclk == v.pol, "R3", "idle level at end", int'(sclk), int'(v.pol));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    repeat (3) @(negedge clk);
    // R11 R10: last bit held, no second transfer
    chk(mosi == bitOf(v.tx, n - 1, n, v.lsb) && busy == 1'b0, "R11",
        "last bit hold", int'(mosi), int'(bitOf(v.tx, n - 1, n, v.lsb)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csN == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "control reset",
        int'({csN, busy, done}), 3'b100);
    chk(sclk == 1'b0 && mosi == 1'b0 && rxData == 16'h0, "R1", "data reset",
        int'({sclk, mosi, rxData}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NVEC; i++) runXfer(VECS[i], 1'b0);
    // R10: write during transfer ignored
    runXfer(VECS[0], 1'b1);
    runXfer(VECS[3], 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule